// File: doc/BRIEF.md
# Multiplexer-Based Perfect Hash Tree

This block turns a short key into a pattern index with no collisions. The key is a reduced bit-vector, made only of the input bit positions that tell the members of one fixed set of known substrings apart. The index selects one candidate entry, so a later stage can fetch that single stored pattern and compare it against the incoming data. The mapping is fixed at elaboration. Within this fixed key set, no two keys can share an index.

The tree is a binary heap of 2-to-1 multiplexer nodes. Each node drives a decision bit, which is the XOR of the key bits picked by that node's mask. Its output is the decision bit on top, followed by the narrower index chosen from one of its two children. The nodes at the bottom take two single key bits, one chosen for each side. The root produces an index of `ID_W` bits, which covers up to `2**ID_W` entries. The width of this index depends only on the entry count, not on the key length.

The index is registered. A key presented with its valid flag gives its index and a valid flag one clock later. The default parameters describe an example set of eight keys.

Top module: `phash_tree`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `id_valid` = 0 and `id` = 0.
- R2: `id_valid` equals the value `key_valid` had at the previous rising edge.
- R3: When `key_valid` is sampled high, the top bit of `id` is set one edge later. Its value is the XOR of the key bits under the root mask. In the default build this is `key[7]^key[6]`.
- R4: In the default build, the two lower `id` bits depend on the root decision.
  - When the root decision is 0, bit 1 is `key[5]`, and bit 0 is `key[1]` if `key[5]` is set and `key[0]` otherwise.
  - When the root decision is 1, bit 1 is `key[4]^key[3]`, and bit 0 is `key[0]` if that XOR is set and `key[2]` otherwise.
- R5: In the default build, the eight keys 0x00, 0x01, 0x20, 0x22, 0x80, 0x84, 0x48 and 0x51 give the indices 0 through 7 in that order. Together they cover every 3-bit index once.
- R6: When `key_valid` is sampled low, `id` keeps its previous value, whatever `key` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| key_valid | input | 1 | Qualifies `key` in this cycle |
| key | input | KEY_W | Reduced key bits |
| id_valid | output | 1 | `id` holds the index of a key taken one cycle earlier |
| id | output | ID_W | Registered pattern index |

## Verification
A wrong mask or leaf position makes one index bit wrong. The error shows one cycle after the key is taken, but only for keys that expose that bit, so random keys are mixed with the directed set. A child mux with its inputs swapped, or a broken decision bit, makes two members of the fixed set share an index. Checking that the set covers all eight indices exposes this. A load enable that ignores the valid flag shows up on the first idle cycle with a changed key.

// File: rtl/phash_pkg.sv
// Package: shared sizing helpers for the hash tree.
// Assumes the index width is at least 2, so the tree has at least one decision node.
package phash_pkg;

    // Number of decision (mask) nodes in a tree with an index of id_w bits.
    function automatic int sel_count(input int id_w);
        return (1 << (id_w - 1)) - 1;
    endfunction

    // Number of single-bit leaf inputs at the bottom of the tree.
    function automatic int term_count(input int id_w);
        return 1 << (id_w - 1);
    endfunction

endpackage

// File: rtl/phash_sel.sv
// Decision bit: the XOR of the key bits chosen by a constant mask.
// Assumes the mask is nonzero; a single set bit degenerates to a wire.
module phash_sel #(
    parameter int              KEY_W = 8,
    parameter logic [KEY_W-1:0] MASK = '0
) (
    input  logic [KEY_W-1:0] key,
    output logic             sel
);

    // Reduce the masked key to one parity bit.
    always_comb begin
        sel = ^(key & MASK);
    end

endmodule

// File: rtl/phash_node.sv
// Tree node: a (K-1)-bit 2-to-1 multiplexer whose select bit becomes the
// top bit of its K-bit output. Assumes K >= 2.
module phash_node #(
    parameter int K = 2
) (
    input  logic         sel,
    input  logic [K-2:0] lo,
    input  logic [K-2:0] hi,
    output logic [K-1:0] out
);

    // Pick the child sub-index and prefix it with the decision bit.
    always_comb begin
        out = {sel, (sel ? hi : lo)};
    end

endmodule

// File: rtl/phash_id_reg.sv
// Output stage: registers the index and its valid flag.
// The index loads only on a valid key. Reset is synchronous and active low.
module phash_id_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);

    // Capture the index on a valid key, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/phash_tree.sv
// Perfect hash tree top.
// Nodes are laid out as a heap: node i has children 2i and 2i+1. Decision
// nodes are 1 .. 2**(ID_W-1)-1, and the single-bit leaves sit below them.
// SEL_MASK packs one KEY_W-bit mask per decision node, node 1 lowest.
// LEAF_POS packs one key bit position per leaf, leaf 0 lowest.
// Assumes the masks and positions were chosen offline so the programmed key set
// maps one-to-one onto the index space.
module phash_tree
    import phash_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int ID_W  = 3,
    parameter logic [sel_count(ID_W)*KEY_W-1:0] SEL_MASK = 24'h18_20_C0,
    parameter logic [term_count(ID_W)*$clog2(KEY_W)-1:0] LEAF_POS = 12'h088
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key,
    output logic             id_valid,
    output logic [ID_W-1:0]  id
);

    localparam int NSEL  = sel_count(ID_W);
    localparam int NTERM = term_count(ID_W);
    localparam int POS_W = $clog2(KEY_W);
    localparam int NODES = NSEL + NTERM;

    // Node outputs, zero-extended to the full index width.
    logic [ID_W-1:0] node_val [1:NODES];

    // Leaves: each one forwards a single chosen key bit.
    for (genvar t = 0; t < NTERM; t++) begin : g_leaf
        localparam logic [POS_W-1:0] POS = LEAF_POS[t*POS_W +: POS_W];
        assign node_val[NTERM + t] = ID_W'(key[POS]);
    end

    // Decision levels: depth d holds 2**d nodes, each producing ID_W-d bits.
    for (genvar d = 0; d < ID_W - 1; d++) begin : g_lvl
        for (genvar j = 0; j < (1 << d); j++) begin : g_nd
            localparam int IDX = (1 << d) + j;
            localparam int K   = ID_W - d;
            logic         sel;
            logic [K-1:0] out_k;

            phash_sel #(
                .KEY_W (KEY_W),
                .MASK  (SEL_MASK[(IDX-1)*KEY_W +: KEY_W])
            ) u_sel (
                .key (key),
                .sel (sel)
            );

            phash_node #(
                .K (K)
            ) u_node (
                .sel (sel),
                .lo  (node_val[2*IDX][K-2:0]),
                .hi  (node_val[2*IDX+1][K-2:0]),
                .out (out_k)
            );

            assign node_val[IDX] = ID_W'(out_k);
        end
    end

    phash_id_reg #(
        .W (ID_W)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (key_valid),
        .d       (node_val[1]),
        .q_valid (id_valid),
        .q       (id)
    );

endmodule

// File: rtl/phash_tree_chk.sv
// Checker for phash_tree, attached by bind.
// Covers reset, valid timing, root decision and hold behaviour.
module phash_tree_chk #(
    parameter int               KEY_W     = 8,
    parameter int               ID_W      = 3,
    parameter logic [KEY_W-1:0] ROOT_MASK = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_valid,
    input logic [KEY_W-1:0] key,
    input logic             id_valid,
    input logic [ID_W-1:0]  id
);

    // R1: reset clears both outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!id_valid && id == '0));

    // R2: the valid flag follows key_valid by one edge.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> id_valid);

    // R2: no valid flag without a taken key.
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> !id_valid);

    // R3: the top index bit is the parity of the key under the root mask.
    a_r3_root_bit: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (id[ID_W-1] == ^($past(key) & ROOT_MASK)));

    // R6: an idle cycle leaves the index unchanged.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> $stable(id));

    // R5: a valid index never carries unknown bits.
    a_r5_known: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> !$isunknown(id));

endmodule

bind phash_tree phash_tree_chk #(
    .KEY_W     (KEY_W),
    .ID_W      (ID_W),
    .ROOT_MASK (SEL_MASK[KEY_W-1:0])
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .key       (key),
    .id_valid  (id_valid),
    .id        (id)
);

// File: tb/phash_tree_tb.sv
// Bench for phash_tree, default build.
// Inputs change on falling edges. Outputs are sampled on the next falling edge.
module phash_tree_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [7:0] key = 8'h00;
    logic       id_valid;
    logic [2:0] id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    phash_tree u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key       (key),
        .id_valid  (id_valid),
        .id        (id)
    );

    // Expected index from the equations in R3 and R4.
    function automatic logic [2:0] model_id(input logic [7:0] k);
        logic r, s;
        r = k[7] ^ k[6];
        if (!r) begin
            s = k[5];
            return {1'b0, s, (s ? k[1] : k[0])};
        end
        s = k[4] ^ k[3];
        return {1'b1, s, (s ? k[0] : k[2])};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle; outputs reflect it at the returned falling edge.
    task automatic step(input logic [7:0] k, input logic v);
        key = k;
        key_valid = v;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] set_keys [8];
        logic [7:0] seen;
        logic [2:0] exp_id;
        set_keys = '{8'h00, 8'h01, 8'h20, 8'h22, 8'h80, 8'h84, 8'h48, 8'h51};
        void'($urandom(32'd1234));

        // R1: a valid key during reset must not get through.
        @(negedge clk);
        step(8'h51, 1'b1);
        step(8'h51, 1'b1);
        check("R1 id_valid", int'(id_valid), 0);
        check("R1 id", int'(id), 0);
        rst_n = 1'b1;

        // R5: the directed key set maps onto 0..7.
        seen = '0;
        for (int i = 0; i < 8; i++) begin
            step(set_keys[i], 1'b1);
            check("R5 index", int'(id), i);
            check("R2 valid", int'(id_valid), 1);
            seen[id] = 1'b1;
        end
        check("R5 coverage", int'(seen), 8'hFF);
        exp_id = 3'd7;

        // R6: an idle cycle with a different key keeps the last index.
        step(8'h00, 1'b0);
        check("R6 hold", int'(id), int'(exp_id));
        check("R2 idle", int'(id_valid), 0);

        // R3/R4/R6: random keys with random valid flags.
        for (int n = 0; n < 400; n++) begin
            logic [7:0] k;
            logic v;
            k = 8'($urandom);
            v = ($urandom % 4) != 0;
            step(k, v);
            if (v) exp_id = model_id(k);
            check("R2 random valid", int'(id_valid), int'(v));
            check(v ? "R3/R4 random index" : "R6 random hold", int'(id), int'(exp_id));
        end

        // R1: a mid-run reset clears the outputs again.
        rst_n = 1'b0;
        step(8'h22, 1'b1);
        check("R1 mid-run id", int'(id), 0);
        check("R1 mid-run valid", int'(id_valid), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule